// File: doc/BRIEF.md
# Edge Change-Detection Interrupt Controller

This block watches a bank of byte-wide digital input ports, whose lines arrive already synchronized to the block clock. It raises a level interrupt to a host when a selected line changes. Each port has two byte-wide enable registers, one for rising edges and one for falling edges, so each line and each polarity is armed separately. Two global switches in an interrupt control register must also be set before an edge of that polarity counts.

Any counted edge sets a sticky edge-seen flag. A counted edge that arrives while the flag is already set also sets a sticky overflow flag. The host reads both flags from a read-only status byte and clears them by writing ones to a clear register. The interrupt line combines each flag with its own enable and then with a master enable.

All registers sit on a simple byte-wide register bus with an address, a write strobe, a read strobe and a write and a read data byte. Read data is registered and returned one cycle after the read strobe.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every enable register and the control register read 0x00, the status byte reads 0x00 and `irq` is low.
- R2: Port p has its rising-edge enable byte at address 0x42 + 0x10*p and its falling-edge enable byte at 0x43 + 0x10*p. Bit i of each byte arms line 8*p+i of `line_in`. The control register is at 0x03. Every one of these reads back the full byte last written to it.
- R3: Status (0x02) is read-only, so a write to it has no effect. The clear register (0x01), address 0x00, the enable addresses of absent ports and every other unmapped address read 0x00.
- R4: A rising edge counts when the line was 0 in the previous cycle and is 1 now, its rising enable bit is set, and control bit 3 is set. A counted edge sets status bit 0 in the same clock.
- R5: A falling edge (1 then 0) counts under the same rule, using the falling enable byte and control bit 4.
- R6: A line change counts neither when its polarity's global control bit is clear nor when its per-line enable bit is clear.
- R7: A counted edge while status bit 0 is already set also sets status bit 1 (overflow).
- R8: A write to 0x01 with bit 3 set clears the edge flag, and with bit 2 set clears the overflow flag. Both may be cleared in one write. Other bits have no effect.
- R9: When a counted edge and a clear of the edge flag fall in the same cycle, the edge flag stays set. If the flag was already set, overflow is set as well.
- R10: `irq` = control bit 2 AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)). It follows a write to control or clear, or a counted edge, in the same clock. Status bit 2 reads this value, and writing 0x00 to control forces `irq` low.
- R11: `bus_rdata` carries the addressed register's value from before the edge on which `bus_rd` was sampled, one cycle after the strobe. It is 0x00 in any cycle after a clock with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| line_in | input | NUM_PORTS*8 | Synchronized input lines, port p at bits 8p+7..8p |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded properties assume that `line_in` is already synchronous to `clk` and stable around each rising edge. They also assume that a bus strobe lasts exactly one cycle with the address and data held for that cycle. The stimulus changes lines and strobes only on the falling edge and never holds a strobe for more than one cycle. It does combine line changes with strobes in the same cycle where a requirement calls for it, such as an edge that meets a clear.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int MAX_PORTS = 12;

  localparam logic [ADDR_W-1:0] ADR_CLEAR  = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 8'h03;

  localparam int PAGE_FIRST = 4;
  localparam logic [3:0] OFS_RISE = 4'h2;
  localparam logic [3:0] OFS_FALL = 4'h3;

  localparam int CTL_EDGE_IE = 0;
  localparam int CTL_OVF_IE  = 1;
  localparam int CTL_MASTER  = 2;
  localparam int CTL_RISE_ON = 3;
  localparam int CTL_FALL_ON = 4;

  localparam int CLR_OVF_BIT  = 2;
  localparam int CLR_EDGE_BIT = 3;

  typedef struct packed {
    logic irq;
    logic ovf;
    logic seen;
  } status_t;
endpackage

// File: rtl/eic_enable_bank.sv
module eic_enable_bank
  import eic_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_PORTS*DATA_W-1:0] rise_en,
  output logic [NUM_PORTS*DATA_W-1:0] fall_en,
  output logic                        rd_hit,
  output logic [DATA_W-1:0]           rd_val
);
  logic [NUM_PORTS-1:0]             sel_page;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rise_q;
  logic [NUM_PORTS-1:0][DATA_W-1:0] fall_q;
  logic                             is_rise;
  logic                             is_fall;

  assign is_rise = (addr[3:0] == OFS_RISE);
  assign is_fall = (addr[3:0] == OFS_FALL);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_page
    localparam logic [3:0] PAGE = 4'(PAGE_FIRST + p);
    assign sel_page[p] = (addr[7:4] == PAGE);
    assign rise_en[p*DATA_W +: DATA_W] = rise_q[p];
    assign fall_en[p*DATA_W +: DATA_W] = fall_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel_page[p] && is_rise) rise_q[p] <= wdata;
        if (sel_page[p] && is_fall) fall_q[p] <= wdata;
      end
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel_page[p] && is_rise) begin
        rd_hit = 1'b1;
        rd_val = rise_q[p];
      end
      if (sel_page[p] && is_fall) begin
        rd_hit = 1'b1;
        rd_val = fall_q[p];
      end
    end
  end

  // R2
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rise_q) && $stable(fall_q))
    else $error("enable byte changed without a write");
endmodule

// File: rtl/eic_edge_detect.sv
module eic_edge_detect
  import eic_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS*DATA_W-1:0] lines,
  input  logic [NUM_PORTS*DATA_W-1:0] rise_en,
  input  logic [NUM_PORTS*DATA_W-1:0] fall_en,
  input  logic                        rise_on,
  input  logic                        fall_on,
  output logic                        hit
);
  localparam int LINES = NUM_PORTS * DATA_W;

  logic [LINES-1:0]     prev_q;
  logic [NUM_PORTS-1:0] port_hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lines;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] now_v, old_v, up_v, down_v;
    assign now_v  = lines[p*DATA_W +: DATA_W];
    assign old_v  = prev_q[p*DATA_W +: DATA_W];
    assign up_v   = now_v & ~old_v & rise_en[p*DATA_W +: DATA_W] & {DATA_W{rise_on}};
    assign down_v = old_v & ~now_v & fall_en[p*DATA_W +: DATA_W] & {DATA_W{fall_on}};
    assign port_hit[p] = |(up_v | down_v);
  end

  assign hit = |port_hit;

  // R6
  quiet_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (lines == $past(lines)) |-> !hit)
    else $error("edge reported on unchanged lines");
endmodule

// File: rtl/eic_flag_unit.sv
module eic_flag_unit
  import eic_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hit,
  input  logic    clr_seen,
  input  logic    clr_ovf,
  input  logic    seen_ie_n,
  input  logic    ovf_ie_n,
  input  logic    master_n,
  output status_t status
);
  logic seen_q, ovf_q, irq_q;
  logic seen_n, ovf_n;

  always_comb begin
    seen_n = hit | (seen_q & ~clr_seen);
    ovf_n  = (hit & seen_q) | (ovf_q & ~clr_ovf);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      seen_q <= seen_n;
      ovf_q  <= ovf_n;
      irq_q  <= master_n & ((seen_n & seen_ie_n) | (ovf_n & ovf_ie_n));
    end
  end

  assign status = '{irq: irq_q, ovf: ovf_q, seen: seen_q};

  // R7
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(seen_q))
    else $error("overflow set without a pending edge");

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> seen_q)
    else $error("counted edge lost");

  // R8
  clear_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_seen && !hit) |=> !seen_q)
    else $error("edge flag survived a clear");

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (seen_q || ovf_q))
    else $error("interrupt without a flag");
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [7:0]                  bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [7:0]                  bus_wdata,
  output logic [7:0]                  bus_rdata,
  input  logic [NUM_PORTS*8-1:0]      line_in,
  output logic                        irq
);
  localparam int LINES = NUM_PORTS * DATA_W;

  logic [DATA_W-1:0] ctrl_q, ctrl_n;
  logic [LINES-1:0]  rise_en, fall_en;
  logic              bank_hit;
  logic [DATA_W-1:0] bank_val;
  logic              hit;
  logic              clr_seen, clr_ovf;
  status_t           status;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    ctrl_n   = (bus_wr && bus_addr == ADR_CTRL) ? bus_wdata : ctrl_q;
    clr_seen = bus_wr && (bus_addr == ADR_CLEAR) && bus_wdata[CLR_EDGE_BIT];
    clr_ovf  = bus_wr && (bus_addr == ADR_CLEAR) && bus_wdata[CLR_OVF_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_n;
  end

  eic_enable_bank #(.NUM_PORTS(NUM_PORTS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .rd_hit  (bank_hit),
    .rd_val  (bank_val)
  );

  eic_edge_detect #(.NUM_PORTS(NUM_PORTS)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .lines   (line_in),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .rise_on (ctrl_q[CTL_RISE_ON]),
    .fall_on (ctrl_q[CTL_FALL_ON]),
    .hit     (hit)
  );

  eic_flag_unit u_flags (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .clr_seen  (clr_seen),
    .clr_ovf   (clr_ovf),
    .seen_ie_n (ctrl_n[CTL_EDGE_IE]),
    .ovf_ie_n  (ctrl_n[CTL_OVF_IE]),
    .master_n  (ctrl_n[CTL_MASTER]),
    .status    (status)
  );

  always_comb begin
    if (bus_addr == ADR_STATUS)    rd_val = {{(DATA_W-3){1'b0}}, status};
    else if (bus_addr == ADR_CTRL) rd_val = ctrl_q;
    else if (bank_hit)             rd_val = bank_val;
    else                           rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign irq       = status.irq;

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0))
    else $error("read data without a read strobe");

  // R6
  no_global_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q[CTL_RISE_ON] || ctrl_q[CTL_FALL_ON]) |-> !hit)
    else $error("edge counted with both polarities off");

  // R10
  master_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CTL_MASTER] |-> !irq)
    else $error("interrupt with master enable off");
endmodule

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  localparam int NP = 4;
  localparam int NL = NP * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NL-1:0] line_in = '0;
  logic          irq;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  edge_irq_ctrl #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]    m_rise [NP];
  logic [7:0]    m_fall [NP];
  logic [7:0]    m_ctrl;
  logic          m_seen, m_ovf, m_irq;
  logic [NL-1:0] m_prev;
  logic [7:0]    m_rdata;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    int pg;
    pg = int'(a[7:4]) - 4;
    if (a == 8'h02) return {5'b0, m_irq, m_ovf, m_seen};
    if (a == 8'h03) return m_ctrl;
    if (pg >= 0 && pg < NP && a[3:0] == 4'h2) return m_rise[pg];
    if (pg >= 0 && pg < NP && a[3:0] == 4'h3) return m_fall[pg];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NP; k++) begin m_rise[k] = 0; m_fall[k] = 0; end
      m_ctrl = 0; m_seen = 0; m_ovf = 0; m_irq = 0; m_prev = 0; m_rdata = 0;
    end else begin
      logic [7:0] rv;
      bit counted;
      int pg;
      rv = bus_rd ? m_read(bus_addr) : 8'h00;
      counted = 0;
      for (int i = 0; i < NL; i++) begin
        if (!m_prev[i] && line_in[i] && m_rise[i/8][i%8] && m_ctrl[3]) counted = 1;
        if (m_prev[i] && !line_in[i] && m_fall[i/8][i%8] && m_ctrl[4]) counted = 1;
      end
      if (counted && m_seen) m_ovf = 1;
      else if (bus_wr && bus_addr == 8'h01 && bus_wdata[2]) m_ovf = 0;
      if (counted) m_seen = 1;
      else if (bus_wr && bus_addr == 8'h01 && bus_wdata[3]) m_seen = 0;
      if (bus_wr) begin
        pg = int'(bus_addr[7:4]) - 4;
        if (bus_addr == 8'h03) m_ctrl = bus_wdata;
        if (pg >= 0 && pg < NP && bus_addr[3:0] == 4'h2) m_rise[pg] = bus_wdata;
        if (pg >= 0 && pg < NP && bus_addr[3:0] == 4'h3) m_fall[pg] = bus_wdata;
      end
      m_irq = m_ctrl[2] & ((m_seen & m_ctrl[0]) | (m_ovf & m_ctrl[1]));
      m_prev = line_in;
      m_rdata = rv;
    end
  end

  // per-cycle comparison against the model (R11 read timing, R10 irq)
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_vec++;
      if (bus_rdata !== m_rdata || irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s (R11/R10 cycle compare) rdata=%h exp %h irq=%b exp %b",
                 cur_req, bus_rdata, m_rdata, irq, m_irq);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_lines(input logic [7:0] a, input logic [7:0] d, input logic [NL-1:0] v);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; line_in = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    line_in = v;
    @(negedge clk);
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    n_vec++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_expect(input logic exp, input string tag);
    n_vec++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R1";
    irq_expect(1'b0, "R1");
    rd_expect(8'h02, 8'h00, "R1");
    rd_expect(8'h03, 8'h00, "R1");
    rd_expect(8'h42, 8'h00, "R1");
    rd_expect(8'h73, 8'h00, "R1");

    cur_req = "R2";
    wr(8'h42, 8'hA5);
    wr(8'h73, 8'h3C);
    wr(8'h52, 8'h81);
    rd_expect(8'h42, 8'hA5, "R2");
    rd_expect(8'h73, 8'h3C, "R2");
    rd_expect(8'h52, 8'h81, "R2");
    rd_expect(8'h43, 8'h00, "R2");
    wr(8'h03, 8'h07);
    rd_expect(8'h03, 8'h07, "R2");

    cur_req = "R3";
    wr(8'h02, 8'hFF);
    rd_expect(8'h02, 8'h00, "R3");
    rd_expect(8'h00, 8'h00, "R3");
    rd_expect(8'h82, 8'h00, "R3");
    rd_expect(8'h01, 8'h00, "R3");
    rd_expect(8'h44, 8'h00, "R3");

    cur_req = "R6";
    wr(8'h42, 8'hFF);
    set_lines(32'h0000_0001);
    rd_expect(8'h02, 8'h00, "R6 global rise off");
    wr(8'h03, 8'h0F);
    set_lines(32'h0001_0001);
    rd_expect(8'h02, 8'h00, "R6 line not armed");

    cur_req = "R4";
    set_lines(32'h0001_0003);
    rd_expect(8'h02, 8'h05, "R4");
    irq_expect(1'b1, "R4");

    cur_req = "R7";
    set_lines(32'h0001_0007);
    rd_expect(8'h02, 8'h07, "R7");

    cur_req = "R8";
    wr(8'h01, 8'hF3);
    rd_expect(8'h02, 8'h07, "R8 other bits");
    wr(8'h01, 8'h08);
    rd_expect(8'h02, 8'h06, "R8 edge clear");
    wr(8'h01, 8'h04);
    rd_expect(8'h02, 8'h00, "R8 ovf clear");
    irq_expect(1'b0, "R8");
    set_lines(32'h0001_000F);
    set_lines(32'h0001_001F);
    rd_expect(8'h02, 8'h07, "R8 refill");
    wr(8'h01, 8'h0C);
    rd_expect(8'h02, 8'h00, "R8 both");

    cur_req = "R5";
    wr(8'h03, 8'h17);
    set_lines(32'h0401_001F);
    rd_expect(8'h02, 8'h00, "R5 rise off");
    set_lines(32'h0001_001F);
    rd_expect(8'h02, 8'h05, "R5");
    set_lines(32'h0001_000F);
    rd_expect(8'h02, 8'h05, "R6 fall not armed");

    cur_req = "R9";
    set_lines(32'h0801_000F);
    wr_lines(8'h01, 8'h08, 32'h0001_000F);
    rd_expect(8'h02, 8'h07, "R9");

    cur_req = "R10";
    wr(8'h03, 8'h13);
    irq_expect(1'b0, "R10 master off");
    rd_expect(8'h02, 8'h03, "R10");
    wr(8'h03, 8'h16);
    irq_expect(1'b1, "R10 ovf path");
    rd_expect(8'h02, 8'h07, "R10");
    wr(8'h01, 8'h04);
    irq_expect(1'b0, "R10 edge ie off");
    rd_expect(8'h02, 8'h01, "R10");
    wr(8'h03, 8'h15);
    irq_expect(1'b1, "R10 edge path");
    rd_expect(8'h02, 8'h05, "R10");
    wr(8'h03, 8'h00);
    irq_expect(1'b0, "R10 all off");
    rd_expect(8'h02, 8'h01, "R10");

    cur_req = "R11";
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule